// File: doc/BRIEF.md
# Guarded Load/Store Data Path

This block is the memory-access stage of a 32-bit processor pipeline. Each cycle it may accept one decoded load or store. The operation carries a guard register value, and it takes effect only when bit 0 of that value is 1. The byte address is formed from a base register plus one of three offsets: an immediate displacement, an index register, or the index register scaled by the access size. The block then checks the address for natural alignment and for range against the attached data memory.

For a store, the block works out the byte lanes to write from the low address bits, the access size and the run-time byte order. It places the data in those lanes and writes a single-port, byte-enabled word memory. For a load, the block reads the word and, one cycle later, extracts 8, 16 or 32 bits. It applies the selected byte order, sign- or zero-extends the result, and requests a register writeback.

Faulty loads raise no error and return zero. Faulty stores are dropped and pulse an error flag.

Top module: `gls_unit`

## Requirements
- R1: When `guard[0]` is 0, the operation changes nothing: no memory byte is written, `wb_valid` stays 0 in the next cycle, and `st_err` stays 0.
- R2: `op_mode` selects how the address is formed. Mode 0 gives base + disp, mode 1 gives base + index, and mode 2 gives base + (index << size). `op_size` is 0 for byte, 1 for half and 2 for word.
- R3: A guarded load that is misaligned or out of range (the address is at least MEM_WORDS*4) still asserts `wb_valid`, returns `wb_data` = 0 and does not assert `st_err`. A half access is misaligned on an odd address. A word access is misaligned when the address is not a multiple of 4.
- R4: A store is accepted only in mode 0. A guarded store in mode 1 or mode 2 writes nothing and pulses `st_err`.
- R5: Mode 2 is legal only for half and word loads. A guarded scaled byte load returns 0 with `wb_valid` set.
- R6: `op_signed`=1 sign-extends byte and half loads to 32 bits. `op_signed`=0 zero-extends them. Word loads return all 32 bits.
- R7: `big_endian`=1 places the most significant byte of a half or word at the lowest address. `big_endian`=0 places the least significant byte there. This applies to both loads and stores. Byte accesses are unaffected by the setting.
- R8: A legal store writes only the bytes it addresses. All other bytes of the word keep their value.
- R9: A guarded store that is misaligned or out of range writes no byte and raises `st_err` for exactly the next cycle.
- R10: Load data and `wb_valid` appear in the cycle after the request. A load issued the cycle after a store to the same bytes sees the new bytes. A load issued the cycle before a store sees the old bytes.
- R11: While `rst_n` is low, `wb_valid` and `st_err` are 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_is_store | input | 1 | 1 for store, 0 for load |
| op_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| op_signed | input | 1 | Load extension: 1 sign, 0 zero |
| op_mode | input | 2 | 0 displacement, 1 index, 2 scaled index |
| guard | input | 32 | Guard register value; bit 0 enables the operation |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 32 | Immediate displacement |
| st_data | input | 32 | Store data, right-aligned |
| big_endian | input | 1 | Byte order select |
| wb_valid | output | 1 | Load writeback request |
| wb_data | output | 32 | Extended load result |
| st_err | output | 1 | One-cycle pulse for a rejected store |

## Verification
The bench builds the block with MEM_WORDS = 16, so the memory holds 64 bytes. With that setting, addresses at 0x40 and above fall outside the memory, and both an out-of-range load and an out-of-range store can be driven with small base values. The vector table chains stores and loads back to back to show that the stored bytes are visible right away. It also checks that untouched lanes are preserved, that scaled and unscaled index modes work, and that stores rejected by mode, alignment or range change nothing.

// File: rtl/gls_pkg.sv
// Shared types and helpers for the guarded load/store path.
// Assumes a 32-bit data word made of four byte lanes; lane k holds the
// byte at word address offset k.
package gls_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        AM_DISP   = 2'd0,
        AM_INDEX  = 2'd1,
        AM_SCALED = 2'd2,
        AM_RSVD   = 2'd3
    } addr_mode_e;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] swap_bytes32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // Reverse the byte order of a 16-bit half.
    function automatic logic [15:0] swap_bytes16(input logic [15:0] x);
        return {x[7:0], x[15:8]};
    endfunction

endpackage

// File: rtl/gls_addr_gen.sv
// Address generation and legality check.
// Forms base + offset, where the offset is the displacement, the index,
// or the index shifted by log2 of the access size. It then reports natural
// alignment, whether the address lies inside the memory, and whether the
// mode and size are allowed for this kind of operation.
// Assumes MEM_BYTES fits in DATA_W bits.
module gls_addr_gen
    import gls_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic              is_store,
    input  acc_size_e         size,
    input  addr_mode_e        mode,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [DATA_W-1:0] disp,
    output logic [DATA_W-1:0] addr,
    output logic              aligned,
    output logic              in_range,
    output logic              mode_ok
);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(MEM_BYTES);

    logic [DATA_W-1:0] offset;

    // Pick the offset added to the base.
    always_comb begin
        unique case (mode)
            AM_DISP:   offset = disp;
            AM_INDEX:  offset = index;
            AM_SCALED: offset = (size == SZ_WORD) ? (index << 2) :
                                (size == SZ_HALF) ? (index << 1) : index;
            default:   offset = '0;
        endcase
    end

    assign addr = base + offset;

    // Natural alignment for the access size.
    always_comb begin
        unique case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = ~addr[0];
            SZ_WORD: aligned = (addr[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase
    end

    assign in_range = (addr < LIMIT);

    // Stores take the displacement form only; the scaled form needs a multi-byte load.
    always_comb begin
        if (size == SZ_RSVD)
            mode_ok = 1'b0;
        else if (is_store)
            mode_ok = (mode == AM_DISP);
        else
            mode_ok = (mode == AM_DISP) || (mode == AM_INDEX) ||
                      ((mode == AM_SCALED) && (size != SZ_BYTE));
    end

endmodule

// File: rtl/gls_store_lanes.sv
// Store lane steering.
// Produces the byte-enable mask and places the right-aligned store data
// into the addressed lanes in the selected byte order.
// Assumes the access is aligned; the caller drops misaligned stores.
module gls_store_lanes
    import gls_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  acc_size_e         size,
    input  logic [1:0]        ofs,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    logic [15:0] half_ord;

    assign half_ord = big_endian ? swap_bytes16(wdata[15:0]) : wdata[15:0];

    // Select the enabled lanes and replicate the data across them.
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be        = LANES'(1) << ofs;
                lane_data = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                be        = LANES'(3) << {ofs[1], 1'b0};
                lane_data = {2{half_ord}};
            end
            SZ_WORD: begin
                be        = '1;
                lane_data = big_endian ? swap_bytes32(wdata) : wdata;
            end
            default: begin
                be        = '0;
                lane_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/gls_load_extract.sv
// Load extraction.
// Picks the addressed byte, half or word out of the memory word, applies
// the byte order and extends it to the full width. It returns zero when
// the access was flagged as not legal.
module gls_load_extract
    import gls_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic              sign_ext,
    input  logic [1:0]        ofs,
    input  logic              big_endian,
    input  logic              legal,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] value
);
    logic [7:0]  sel_byte;
    logic [15:0] raw_half;
    logic [15:0] sel_half;

    assign sel_byte = word[8*ofs +: 8];
    assign raw_half = ofs[1] ? word[31:16] : word[15:0];
    assign sel_half = big_endian ? swap_bytes16(raw_half) : raw_half;

    // Extend the selected item, or return zero for an illegal access.
    always_comb begin
        if (!legal)
            value = '0;
        else begin
            unique case (size)
                SZ_BYTE: value = {{(DATA_W-8){sign_ext & sel_byte[7]}}, sel_byte};
                SZ_HALF: value = {{(DATA_W-16){sign_ext & sel_half[15]}}, sel_half};
                SZ_WORD: value = big_endian ? swap_bytes32(word) : word;
                default: value = '0;
            endcase
        end
    end

endmodule

// File: rtl/gls_data_mem.sv
// Single-port, byte-enabled word memory with a synchronous read.
// A write and a read are never requested in the same cycle. The contents
// are not reset.
module gls_data_mem #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 256,
    localparam int AW    = $clog2(WORDS),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     waddr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write the enabled lanes, or register a read of the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++)
                if (be[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
        end
        if (re)
            rdata <= mem[waddr];
    end

endmodule

// File: rtl/gls_unit.sv
// Guarded load/store stage, top level.
// Accepts one operation per cycle. Bit 0 of the guard enables it.
// Stores write memory on the accepting edge. Rejected stores pulse st_err
// one cycle later. Loads return extended data one cycle after the request.
// Assumes DATA_W is 32 and MEM_WORDS is a power of two.
module gls_unit
    import gls_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_store,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] guard,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [DATA_W-1:0] disp,
    input  logic [DATA_W-1:0] st_data,
    input  logic              big_endian,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic              st_err
);
    acc_size_e         size;
    addr_mode_e        mode;
    logic [DATA_W-1:0] addr;
    logic              aligned, in_range, mode_ok, acc_ok;
    logic              op_take, mem_we, mem_re;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] lane_data, rdata, ld_value;

    // Registered load attributes, used in the cycle the data returns.
    acc_size_e         size_q;
    logic              sign_q, be_order_q, ok_q, wbv_q, err_q;
    logic [1:0]        ofs_q;

    assign size = acc_size_e'(op_size);
    assign mode = addr_mode_e'(op_mode);

    gls_addr_gen #(.DATA_W(DATA_W), .MEM_BYTES(MEM_WORDS * LANES)) u_addr (
        .is_store (op_is_store),
        .size     (size),
        .mode     (mode),
        .base     (base),
        .index    (index),
        .disp     (disp),
        .addr     (addr),
        .aligned  (aligned),
        .in_range (in_range),
        .mode_ok  (mode_ok)
    );

    gls_store_lanes #(.DATA_W(DATA_W)) u_lanes (
        .size       (size),
        .ofs        (addr[1:0]),
        .big_endian (big_endian),
        .wdata      (st_data),
        .be         (be),
        .lane_data  (lane_data)
    );

    assign op_take = op_valid & guard[0];
    assign acc_ok  = aligned & in_range & mode_ok;
    assign mem_we  = op_take & op_is_store & acc_ok;
    assign mem_re  = op_take & ~op_is_store;

    gls_data_mem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .waddr (addr[AW+1:2]),
        .be    (be),
        .wdata (lane_data),
        .rdata (rdata)
    );

    // Status registers: writeback request and store error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbv_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            wbv_q <= mem_re;
            err_q <= op_take & op_is_store & ~acc_ok;
        end
    end

    // Capture the load attributes alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q     <= SZ_BYTE;
            sign_q     <= 1'b0;
            be_order_q <= 1'b0;
            ok_q       <= 1'b0;
            ofs_q      <= '0;
        end else if (mem_re) begin
            size_q     <= size;
            sign_q     <= op_signed;
            be_order_q <= big_endian;
            ok_q       <= acc_ok;
            ofs_q      <= addr[1:0];
        end
    end

    gls_load_extract #(.DATA_W(DATA_W)) u_extract (
        .size       (size_q),
        .sign_ext   (sign_q),
        .ofs        (ofs_q),
        .big_endian (be_order_q),
        .legal      (ok_q),
        .word       (rdata),
        .value      (ld_value)
    );

    assign wb_valid = wbv_q;
    assign wb_data  = wbv_q ? ld_value : '0;
    assign st_err   = err_q;

endmodule

// File: rtl/gls_unit_chk.sv
// Protocol checker for gls_unit, attached with bind. It relates the guard
// and operation inputs to the write strobe, the writeback request and the
// store error pulse.
module gls_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_is_store,
    input logic [1:0]        op_size,
    input logic              op_signed,
    input logic [1:0]        op_mode,
    input logic [DATA_W-1:0] guard,
    input logic              mem_we,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data,
    input logic              st_err
);
    p_no_write_unguarded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op_valid && guard[0] && op_is_store));

    p_wb_needs_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(op_valid && guard[0] && !op_is_store));

    p_store_disp_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op_mode == 2'd0));

    p_err_from_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(op_valid && guard[0] && op_is_store));

    p_load_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op_valid && guard[0] && !op_is_store) |-> wb_valid);

    p_ubyte_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op_valid && guard[0] && !op_is_store &&
              op_size == 2'd0 && !op_signed) |-> (wb_data[DATA_W-1:8] == '0));

endmodule

bind gls_unit gls_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_is_store (op_is_store),
    .op_size     (op_size),
    .op_signed   (op_signed),
    .op_mode     (op_mode),
    .guard       (guard),
    .mem_we      (mem_we),
    .wb_valid    (wb_valid),
    .wb_data     (wb_data),
    .st_err      (st_err)
);

// File: tb/gls_unit_tb.sv
// Vector-driven bench for gls_unit, followed by directed reset tests.
module gls_unit_tb;

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic        sg;
        logic [1:0]  md;
        logic        g;
        logic        bend;
        logic [7:0]  base;
        logic [7:0]  idx;
        logic [7:0]  disp;
        logic [31:0] data;
        logic        wbv;
        logic [31:0] wbd;
        logic        err;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t mk(logic st, logic [1:0] sz, logic sg, logic [1:0] md,
                                logic g, logic bend, logic [7:0] base, logic [7:0] idx,
                                logic [7:0] disp, logic [31:0] data, logic wbv,
                                logic [31:0] wbd, logic err, logic [3:0] rq);
        return '{st, sz, sg, md, g, bend, base, idx, disp, data, wbv, wbd, err, rq};
    endfunction

    localparam int NV = 37;
    // Fields: st sz sg md g bend base idx disp data | wbv wbd err | req
    localparam vec_t VEC [NV] = '{
        mk(1,2,0,0,1,0,8'h10,0,0,32'h11223344, 0,0,0, 10),          // R10 store word
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h11223344,0, 10),          // R10 load sees new bytes
        mk(0,2,0,0,1,1,8'h10,0,0,0, 1,32'h44332211,0, 7),           // R7 big-endian word
        mk(0,0,0,0,1,0,8'h10,0,1,0, 1,32'h00000033,0, 6),           // R6 unsigned byte
        mk(1,2,0,0,1,0,8'h20,0,0,32'h0, 0,0,0, 8),                  // R8 clear word
        mk(1,1,0,0,1,1,8'h20,0,2,32'h000080F0, 0,0,0, 7),           // R7 big-endian half store
        mk(0,2,0,0,1,0,8'h20,0,0,0, 1,32'hF0800000,0, 8),           // R8 other lanes kept
        mk(0,1,1,0,1,0,8'h20,0,2,0, 1,32'hFFFFF080,0, 6),           // R6 signed half LE
        mk(0,1,0,0,1,1,8'h20,0,2,0, 1,32'h000080F0,0, 7),           // R7 unsigned half BE
        mk(0,1,1,0,1,1,8'h20,0,2,0, 1,32'hFFFF80F0,0, 6),           // R6 signed half BE
        mk(0,0,1,0,1,0,8'h20,0,3,0, 1,32'hFFFFFFF0,0, 6),           // R6 signed byte
        mk(0,2,0,1,1,0,8'h08,8'h08,0,0, 1,32'h11223344,0, 2),       // R2 index mode
        mk(0,1,1,2,1,0,8'h20,8'h01,0,0, 1,32'hFFFFF080,0, 2),       // R2 scaled half
        mk(0,2,0,2,1,0,8'h00,8'h04,0,0, 1,32'h11223344,0, 2),       // R2 scaled word
        mk(0,0,0,2,1,0,8'h10,8'h00,0,0, 1,32'h0,0, 5),              // R5 scaled byte illegal
        mk(0,1,0,0,1,0,8'h10,0,1,0, 1,32'h0,0, 3),                  // R3 odd half
        mk(0,2,0,0,1,0,8'h10,0,2,0, 1,32'h0,0, 3),                  // R3 misaligned word
        mk(0,2,0,0,1,0,8'h40,0,0,0, 1,32'h0,0, 3),                  // R3 out of range
        mk(0,2,0,0,0,0,8'h10,0,0,0, 0,32'h0,0, 1),                  // R1 unguarded load
        mk(1,2,0,0,0,0,8'h10,0,0,32'hDEADBEEF, 0,0,0, 1),           // R1 unguarded store
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h11223344,0, 1),           // R1 memory unchanged
        mk(1,2,0,1,1,0,8'h10,0,0,32'h0, 0,0,1, 4),                  // R4 index store rejected
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h11223344,0, 4),           // R4 no write, pulse ended
        mk(1,2,0,0,1,0,8'h10,0,2,32'h0, 0,0,1, 9),                  // R9 misaligned store
        mk(1,2,0,0,1,0,8'h44,0,0,32'h0, 0,0,1, 9),                  // R9 out-of-range store
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h11223344,0, 9),           // R9 nothing written
        mk(1,0,0,0,1,1,8'h10,0,1,32'h000000AA, 0,0,0, 8),           // R8 byte store
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h1122AA44,0, 8),           // R8 single lane changed
        mk(1,2,0,0,1,0,8'h10,0,0,32'h55667788, 0,0,0, 10),          // R10 store after load
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h55667788,0, 10),          // R10 new value visible
        mk(1,2,0,0,1,1,8'h30,0,0,32'h01020304, 0,0,0, 7),           // R7 big-endian word store
        mk(0,2,0,0,1,0,8'h30,0,0,0, 1,32'h04030201,0, 7),           // R7 read back LE
        mk(0,0,0,0,1,1,8'h30,0,0,0, 1,32'h00000001,0, 7),           // R7 byte ignores order
        mk(1,1,0,0,1,0,8'h30,0,2,32'h0000BEEF, 0,0,0, 8),           // R8 LE half store
        mk(0,2,0,0,1,0,8'h30,0,0,0, 1,32'hBEEF0201,0, 8),           // R8 upper half only
        mk(1,2,0,2,1,0,8'h10,0,0,32'h0, 0,0,1, 4),                  // R4 scaled store rejected
        mk(0,2,0,0,1,0,8'h10,0,0,0, 1,32'h55667788,0, 4)            // R4 memory unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_is_store, op_signed, big_endian;
    logic [1:0]  op_size, op_mode;
    logic [31:0] guard, base, index, disp, st_data;
    logic        wb_valid, st_err;
    logic [31:0] wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gls_unit #(.DATA_W(32), .MEM_WORDS(16)) u_dut (
        .clk, .rst_n, .op_valid, .op_is_store, .op_size, .op_signed, .op_mode,
        .guard, .base, .index, .disp, .st_data, .big_endian,
        .wb_valid, .wb_data, .st_err
    );

    task automatic idle();
        op_valid = 0; op_is_store = 0; op_size = 0; op_signed = 0; op_mode = 0;
        guard = 0; base = 0; index = 0; disp = 0; st_data = 0; big_endian = 0;
    endtask

    task automatic check_outs(string tag, logic ev, logic [31:0] ed, logic ee);
        n_checks++;
        if (wb_valid !== ev || (ev && wb_data !== ed) || st_err !== ee) begin
            n_fail++;
            $display("FAIL %s: wb_valid=%0b wb_data=%08h st_err=%0b expected %0b %08h %0b",
                     tag, wb_valid, wb_data, st_err, ev, ed, ee);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check_outs("R11 reset state", 0, 0, 0);
        rst_n = 1;

        // Walk the vector table; each row is checked one edge after it is driven.
        for (int i = 0; i < NV; i++) begin
            op_valid    = 1;
            op_is_store = VEC[i].st;
            op_size     = VEC[i].sz;
            op_signed   = VEC[i].sg;
            op_mode     = VEC[i].md;
            guard       = {30'h0, 1'b1, VEC[i].g};
            big_endian  = VEC[i].bend;
            base        = {24'h0, VEC[i].base};
            index       = {24'h0, VEC[i].idx};
            disp        = {24'h0, VEC[i].disp};
            st_data     = VEC[i].data;
            @(posedge clk);
            #1;
            check_outs($sformatf("row %0d (R%0d)", i, VEC[i].rq),
                       VEC[i].wbv, VEC[i].wbd, VEC[i].err);
        end

        // R11: reset overrides a guarded load and a bad store presented at the same edge.
        op_valid = 1; op_is_store = 0; op_size = 2; op_mode = 0; guard = 1;
        base = 32'h10; disp = 0;
        rst_n = 0;
        @(posedge clk);
        #1;
        check_outs("R11 reset blocks load", 0, 0, 0);
        op_is_store = 1; disp = 2;
        @(posedge clk);
        #1;
        check_outs("R11 reset blocks error", 0, 0, 0);
        rst_n = 1;

        // R9: a single rejected store gives a one-cycle pulse.
        @(posedge clk);
        #1;
        check_outs("R9 bad store pulses", 0, 0, 1);
        idle();
        @(posedge clk);
        #1;
        check_outs("R9 pulse ends", 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule